// File: doc/BRIEF.md
# Indexed-Color Display Controller Register Bank

This block is the host-visible control register bank of an 8-bit indexed-color framebuffer controller. A host reaches it over a plain address/data bus with separate read and write strobes and a size code that selects a byte, halfword or full 32-bit access. Every value the pixel pipeline needs is held here. That covers a 256-entry RGB color lookup table, three cursor colors, a 512-word two-bit-per-pixel cursor bitmap, the cursor position, a control word, the frame start offset and the visible width and height.

The pixel pipeline reads the two large tables through dedicated lookup ports, each with one cycle of latency. It sees the small registers directly as decoded outputs: pixel depth, forced blanking and cursor disable. The tables sit at an 8-byte stride inside fixed address windows. The geometry registers scale the value on the way in and back on the way out. A write to a dedicated clear address empties the whole bank. Writes to the video timing registers, and to any other unmapped offset, are absorbed without effect. Each write also raises a one-cycle pulse that tells the interrupt logic to drop the frame interrupt.

Top module: `fb_ctrl_regfile`

## Requirements
- R1: After reset every register output, `irq_clr` and `bus_rdata` are zero. Every color-table entry and every cursor-bitmap word reads as zero on both the bus and the lookup ports. A read returns its data on `bus_rdata` in the cycle after the cycle in which `bus_rd` is high, and the data holds until the next read.
- R2: Color-table entry i sits at word offset 0x080800 + 8*i. A write loads red from bits 23:16, green from bits 15:8 and blue from bits 7:0, and drops bits 31:24. A bus read returns {8'h00, R, G, B}. The lookup port returns {R, G, B} for `pix_index` one cycle after the index is presented.
- R3: Cursor-bitmap word i (16 bits) sits at word offset 0x081000 + 8*i and is readable and writable. A read returns it in bits 15:0. The lookup port returns it for `curs_index` one cycle later. A byte or halfword write to lanes 2 or 3 leaves the word unchanged.
- R4: Cursor color k (k = 0..2) sits at 0x080508 + 8*k and is packed and read back like a color-table entry. `curs_rgb[24*k +: 24]` holds color k.
- R5: Writing v to 0x080118 sets `disp_width` = 4*v (mod 2^32), and a read there returns `disp_width` / 4. Writing v to 0x080150 sets `disp_height` = floor(v/2), and a read there returns 2*`disp_height`.
- R6: The control word at 0x080300 is read/write and appears on `ctrl_word`. Its bits 22:20 select `pix_depth` from the table 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6→0, 7→0. Bit 10 drives `force_blank` and bit 23 drives `cursor_off`.
- R7: The frame start offset at 0x080400 and the cursor position at 0x080638 are full 32-bit read/write registers. They appear on `top_offset` and `curs_pos`.
- R8: Writes to the timing registers (0x080000, 0x080108 to 0x080170, 0x080200) and to any unmapped offset change no register or table. Reads of unmapped offsets return zero.
- R9: Any write to 0x180000 zeroes all registers, all three cursor colors, every color-table entry and every cursor-bitmap word. A later narrow write to a cleared table word fills its other lanes with zero.
- R10: `bus_size` 0 is a byte, 1 a halfword and 2 or 3 a word. `bus_addr[1:0]` selects the byte lane, and for a halfword `bus_addr[1]` selects the half. A narrow read returns the selected lane at bit 0. A narrow write takes its value from the low bits of `bus_wdata` and replaces only that lane of the register's read-back value.
- R11: `irq_clr` is high for exactly the cycle after each cycle in which `bus_wr` is high, and low otherwise.
- R12: Offset 0 is a read-only identifier that returns 0x00000010, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 21 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data, narrow values in the low bits |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| pix_index | input | 8 | Color-table lookup index |
| pix_rgb | output | 24 | Looked-up color {R,G,B}, one cycle later |
| curs_index | input | 9 | Cursor-bitmap lookup index |
| curs_bits | output | 16 | Looked-up cursor word, one cycle later |
| curs_rgb | output | 72 | Three cursor colors, color k at bits 24k+23:24k |
| curs_pos | output | 32 | Cursor position |
| top_offset | output | 32 | Frame start offset |
| ctrl_word | output | 32 | Control word |
| pix_depth | output | 5 | Decoded bits per pixel |
| force_blank | output | 1 | Blank the display |
| cursor_off | output | 1 | Hide the cursor |
| disp_width | output | 32 | Visible width in pixels |
| disp_height | output | 32 | Visible height in lines |
| irq_clr | output | 1 | One-cycle pulse that drops the frame interrupt |

## Verification
A wrong valid flag or a missed zero-fill in either table shows up as stale bytes in the first bus or lookup read after a clear or a first narrow write. It is visible one cycle after that read is issued. A bad lane mask or a bad merge corrupts the neighbouring lanes of a register, and the register output ports show this in the very next cycle. A scaling error in the geometry registers shows at once on `disp_width`/`disp_height` and again on read-back. For this reason the sweeps write every table entry with a value computed from its index and read each one back, and they read back each narrow write at the ports.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned BUS_AW = 21;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_ID    = 21'h000000;
  localparam logic [BUS_AW-1:0] OFS_HDISP = 21'h080118;
  localparam logic [BUS_AW-1:0] OFS_VDISP = 21'h080150;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 21'h080300;
  localparam logic [BUS_AW-1:0] OFS_TOP   = 21'h080400;
  localparam logic [BUS_AW-1:0] OFS_CPAL  = 21'h080508;
  localparam logic [BUS_AW-1:0] OFS_CPOS  = 21'h080638;
  localparam logic [BUS_AW-1:0] OFS_PAL   = 21'h080800;
  localparam logic [BUS_AW-1:0] OFS_PAT   = 21'h081000;
  localparam logic [BUS_AW-1:0] OFS_CLEAR = 21'h180000;

  localparam logic [BUS_DW-1:0] ID_VALUE = 32'h0000_0010;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;
  typedef enum logic [1:0] {SRC_REG = 2'd0, SRC_PAL = 2'd1, SRC_PAT = 2'd2} rsrc_e;

  // lanes touched by an access
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] lane);
    if (size == SZ_BYTE)      return 4'b0001 << lane;
    else if (size == SZ_HALF) return lane[1] ? 4'b1100 : 4'b0011;
    else                      return 4'b1111;
  endfunction

  // narrow write data replicated onto every lane
  function automatic logic [31:0] spread(input logic [31:0] d, input logic [1:0] size);
    if (size == SZ_BYTE)      return {4{d[7:0]}};
    else if (size == SZ_HALF) return {2{d[15:0]}};
    else                      return d;
  endfunction

  function automatic logic [31:0] merge_lanes(input logic [31:0] old_w, input logic [31:0] new_w,
                                              input logic [3:0] m);
    logic [31:0] m32;
    m32 = {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    return (old_w & ~m32) | (new_w & m32);
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] w, input logic [1:0] size,
                                          input logic [1:0] lane);
    logic [31:0] t;
    t = w >> {lane, 3'b000};
    if (size == SZ_BYTE)      return {24'h0, t[7:0]};
    else if (size == SZ_HALF) return lane[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    else                      return w;
  endfunction

  function automatic logic [4:0] depth_of(input logic [2:0] sel);
    case (sel)
      3'd0: return 5'd1;
      3'd1: return 5'd2;
      3'd2: return 5'd4;
      3'd3: return 5'd8;
      3'd4: return 5'd15;
      3'd5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/dcr_ram.sv
// Byte-lane table: one write/read port for the host, one read port for pixels.
// Per-entry valid bits give a one-cycle clear without touching the storage.
module dcr_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LANES = 3,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned DW = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [LANES-1:0] a_we,
  input  logic             a_re,
  input  logic [AW-1:0]    a_addr,
  input  logic [DW-1:0]    a_wdata,
  output logic [DW-1:0]    a_rdata,
  input  logic [AW-1:0]    b_addr,
  output logic [DW-1:0]    b_rdata
);
  logic [DEPTH-1:0] vld;
  logic a_vq, b_vq;
  logic any_we;

  assign any_we = |a_we;

  always_ff @(posedge clk) begin
    if (rst || clr)  vld <= '0;
    else if (any_we) vld[a_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vq <= 1'b0;
      b_vq <= 1'b0;
    end else begin
      if (a_re) a_vq <= vld[a_addr];
      b_vq <= vld[b_addr];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] qa, qb;
    always_ff @(posedge clk) begin
      // a stale entry gets its unwritten lanes zero-filled
      if (any_we && (a_we[l] || !vld[a_addr]))
        mem[a_addr] <= a_we[l] ? a_wdata[8*l +: 8] : 8'h00;
      if (a_re) qa <= mem[a_addr];
      qb <= mem[b_addr];
    end
    assign a_rdata[8*l +: 8] = a_vq ? qa : 8'h00;
    assign b_rdata[8*l +: 8] = b_vq ? qb : 8'h00;
  end
endmodule

// File: rtl/dcr_ctrl_regs.sv
module dcr_ctrl_regs import dcr_pkg::*; #(
  parameter int unsigned CPAL_N = 3,
  localparam int unsigned CPAL_AW = (CPAL_N > 1) ? $clog2(CPAL_N) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  we_hdisp,
  input  logic                  we_vdisp,
  input  logic                  we_ctrl,
  input  logic                  we_top,
  input  logic                  we_pos,
  input  logic                  we_cpal,
  input  logic [CPAL_AW-1:0]    cpal_idx,
  input  logic [31:0]           wword,
  output logic [31:0]           width,
  output logic [31:0]           height,
  output logic [31:0]           ctrl,
  output logic [31:0]           top,
  output logic [31:0]           pos,
  output logic [24*CPAL_N-1:0]  cpal,
  output logic [4:0]            depth,
  output logic                  blank,
  output logic                  nocurs
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      width  <= '0;
      height <= '0;
      ctrl   <= '0;
      top    <= '0;
      pos    <= '0;
    end else begin
      if (we_hdisp) width  <= {wword[29:0], 2'b00};
      if (we_vdisp) height <= {1'b0, wword[31:1]};
      if (we_ctrl)  ctrl   <= wword;
      if (we_top)   top    <= wword;
      if (we_pos)   pos    <= wword;
    end
  end

  for (genvar e = 0; e < CPAL_N; e++) begin : g_cpal
    always_ff @(posedge clk) begin
      if (rst || clr)
        cpal[24*e +: 24] <= '0;
      else if (we_cpal && cpal_idx == CPAL_AW'(e))
        cpal[24*e +: 24] <= wword[23:0];
    end
  end

  assign depth  = depth_of(ctrl[22:20]);
  assign blank  = ctrl[10];
  assign nocurs = ctrl[23];
endmodule

// File: rtl/fb_ctrl_regfile.sv
module fb_ctrl_regfile import dcr_pkg::*; #(
  parameter int unsigned PAL_DEPTH = 256,
  parameter int unsigned PAT_DEPTH = 512,
  parameter int unsigned CPAL_N    = 3,
  localparam int unsigned PAL_AW  = $clog2(PAL_DEPTH),
  localparam int unsigned PAT_AW  = $clog2(PAT_DEPTH),
  localparam int unsigned CPAL_AW = (CPAL_N > 1) ? $clog2(CPAL_N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [20:0]          bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_size,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [PAL_AW-1:0]    pix_index,
  output logic [23:0]          pix_rgb,
  input  logic [PAT_AW-1:0]    curs_index,
  output logic [15:0]          curs_bits,
  output logic [24*CPAL_N-1:0] curs_rgb,
  output logic [31:0]          curs_pos,
  output logic [31:0]          top_offset,
  output logic [31:0]          ctrl_word,
  output logic [4:0]           pix_depth,
  output logic                 force_blank,
  output logic                 cursor_off,
  output logic [31:0]          disp_width,
  output logic [31:0]          disp_height,
  output logic                 irq_clr
);
  localparam logic [20:0] PAL_END  = OFS_PAL  + 21'(PAL_DEPTH * 8);
  localparam logic [20:0] PAT_END  = OFS_PAT  + 21'(PAT_DEPTH * 8);
  localparam logic [20:0] CPAL_END = OFS_CPAL + 21'(CPAL_N * 8);

  logic [20:0] waddr;
  logic [1:0]  lane;
  logic        hit_pal, hit_pat, hit_cpal, clr;
  logic [PAL_AW-1:0]  pal_idx;
  logic [PAT_AW-1:0]  pat_idx;
  logic [CPAL_AW-1:0] cpal_idx;
  logic [3:0]  wmask;
  logic [31:0] wspread, old_word, merged;
  logic [23:0] pal_q;
  logic [15:0] pat_q;

  assign waddr    = {bus_addr[20:2], 2'b00};
  assign lane     = bus_addr[1:0];
  assign hit_pal  = (waddr >= OFS_PAL)  && (waddr < PAL_END);
  assign hit_pat  = (waddr >= OFS_PAT)  && (waddr < PAT_END);
  assign hit_cpal = (waddr >= OFS_CPAL) && (waddr < CPAL_END);
  assign pal_idx  = PAL_AW'((waddr - OFS_PAL) >> 3);
  assign pat_idx  = PAT_AW'((waddr - OFS_PAT) >> 3);
  assign cpal_idx = CPAL_AW'((waddr - OFS_CPAL) >> 3);
  assign clr      = bus_wr && (waddr == OFS_CLEAR);

  // read-back view of the register-type targets, used for reads and narrow-write merge
  always_comb begin
    old_word = '0;
    if (hit_cpal) old_word = {8'h00, curs_rgb[24*cpal_idx +: 24]};
    else begin
      case (waddr)
        OFS_ID:    old_word = ID_VALUE;
        OFS_HDISP: old_word = {2'b00, disp_width[31:2]};
        OFS_VDISP: old_word = {disp_height[30:0], 1'b0};
        OFS_CTRL:  old_word = ctrl_word;
        OFS_TOP:   old_word = top_offset;
        OFS_CPOS:  old_word = curs_pos;
        default:   old_word = '0;
      endcase
    end
  end

  assign wmask   = lane_mask(bus_size, lane);
  assign wspread = spread(bus_wdata, bus_size);
  assign merged  = merge_lanes(old_word, wspread, wmask);

  dcr_ram #(.DEPTH(PAL_DEPTH), .LANES(3)) u_pal (
    .clk(clk), .rst(rst), .clr(clr),
    .a_we((bus_wr && hit_pal) ? wmask[2:0] : 3'b000),
    .a_re(bus_rd && hit_pal), .a_addr(pal_idx), .a_wdata(wspread[23:0]),
    .a_rdata(pal_q), .b_addr(pix_index), .b_rdata(pix_rgb));

  dcr_ram #(.DEPTH(PAT_DEPTH), .LANES(2)) u_pat (
    .clk(clk), .rst(rst), .clr(clr),
    .a_we((bus_wr && hit_pat) ? wmask[1:0] : 2'b00),
    .a_re(bus_rd && hit_pat), .a_addr(pat_idx), .a_wdata(wspread[15:0]),
    .a_rdata(pat_q), .b_addr(curs_index), .b_rdata(curs_bits));

  dcr_ctrl_regs #(.CPAL_N(CPAL_N)) u_regs (
    .clk(clk), .rst(rst), .clr(clr),
    .we_hdisp(bus_wr && waddr == OFS_HDISP),
    .we_vdisp(bus_wr && waddr == OFS_VDISP),
    .we_ctrl (bus_wr && waddr == OFS_CTRL),
    .we_top  (bus_wr && waddr == OFS_TOP),
    .we_pos  (bus_wr && waddr == OFS_CPOS),
    .we_cpal (bus_wr && hit_cpal),
    .cpal_idx(cpal_idx), .wword(merged),
    .width(disp_width), .height(disp_height), .ctrl(ctrl_word),
    .top(top_offset), .pos(curs_pos), .cpal(curs_rgb),
    .depth(pix_depth), .blank(force_blank), .nocurs(cursor_off));

  // read pipeline: one registered stage
  rsrc_e       rd_src;
  logic [31:0] rd_word, rd_sel;
  logic [1:0]  rd_size, rd_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src  <= SRC_REG;
      rd_word <= '0;
      rd_size <= SZ_WORD;
      rd_lane <= '0;
      irq_clr <= 1'b0;
    end else begin
      irq_clr <= bus_wr;
      if (bus_rd) begin
        rd_src  <= hit_pal ? SRC_PAL : (hit_pat ? SRC_PAT : SRC_REG);
        rd_word <= old_word;
        rd_size <= bus_size;
        rd_lane <= lane;
      end
    end
  end

  always_comb begin
    case (rd_src)
      SRC_PAL: rd_sel = {8'h00, pal_q};
      SRC_PAT: rd_sel = {16'h0000, pat_q};
      default: rd_sel = rd_word;
    endcase
  end
  assign bus_rdata = extract(rd_sel, rd_size, rd_lane);

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> irq_clr); // R11
  AST_IRQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> !irq_clr); // R11
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[20:2] == OFS_CLEAR[20:2]) |=>
      (disp_width == 0 && disp_height == 0 && ctrl_word == 0 &&
       top_offset == 0 && curs_pos == 0 && curs_rgb == 0)); // R9
  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_ID && bus_size == SZ_WORD) |=> bus_rdata == ID_VALUE); // R12
  AST_TIMING_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[20:2] == 19'h20042) |=>
      ($stable(ctrl_word) && $stable(disp_width) && $stable(disp_height) &&
       $stable(top_offset) && $stable(curs_pos))); // R8
  AST_WIDTH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    disp_width[1:0] == 2'b00); // R5
endmodule

// File: tb/test_fb_ctrl_regfile.sv
module test_fb_ctrl_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [20:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  pix_index;
  logic [23:0] pix_rgb;
  logic [8:0]  curs_index;
  logic [15:0] curs_bits;
  logic [71:0] curs_rgb;
  logic [31:0] curs_pos, top_offset, ctrl_word, disp_width, disp_height;
  logic [4:0]  pix_depth;
  logic        force_blank, cursor_off, irq_clr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fb_ctrl_regfile i_fb_ctrl_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_index(pix_index), .pix_rgb(pix_rgb), .curs_index(curs_index),
    .curs_bits(curs_bits), .curs_rgb(curs_rgb), .curs_pos(curs_pos),
    .top_offset(top_offset), .ctrl_word(ctrl_word), .pix_depth(pix_depth),
    .force_blank(force_blank), .cursor_off(cursor_off), .disp_width(disp_width),
    .disp_height(disp_height), .irq_clr(irq_clr));

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pix(input logic [7:0] i, output logic [23:0] c);
    @(negedge clk);
    pix_index = i;
    @(negedge clk);
    c = pix_rgb;
  endtask

  task automatic curs(input logic [8:0] i, output logic [15:0] w);
    @(negedge clk);
    curs_index = i;
    @(negedge clk);
    w = curs_bits;
  endtask

  function automatic logic [23:0] pal_val(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b, ~b, b ^ 8'h5A};
  endfunction

  function automatic logic [4:0] exp_depth(input int s);
    case (s)
      0: return 5'd1;  1: return 5'd2;  2: return 5'd4;
      3: return 5'd8;  4: return 5'd15; 5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [23:0] c;
    logic [15:0] w;
    logic [31:0] s_ctrl, s_w, s_h, s_top, s_pos;
    logic [71:0] s_crgb;

    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_size = 2'd2;
    bus_wdata = '0; pix_index = '0; curs_index = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 width", disp_width, 0);
    check("R1 height", disp_height, 0);
    check("R1 ctrl", ctrl_word, 0);
    check("R1 top", top_offset, 0);
    check("R1 pos", curs_pos, 0);
    check("R1 curs_rgb", curs_rgb, 0);
    check("R1 irq_clr", irq_clr, 0);
    check("R1 rdata", bus_rdata, 0);
    rd(21'h080800 + 21'(8*5), 2'd2, d); check("R1 palette read", d, 0);
    rd(21'h081000 + 21'(8*7), 2'd2, d); check("R1 pattern read", d, 0);
    pix(8'd7, c);  check("R1 pix lookup", c, 0);
    curs(9'd300, w); check("R1 curs lookup", w, 0);

    // R12 identifier
    rd(21'h0, 2'd2, d); check("R12 id", d, 32'h10);
    wr(21'h0, 2'd2, 32'h5555_5555);
    rd(21'h0, 2'd2, d); check("R12 id after write", d, 32'h10);
    check("R1 rdata holds", bus_rdata, 32'h10);

    // R11 irq pulse timing
    @(negedge clk);
    bus_addr = 21'h080400; bus_size = 2'd2; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R11 pulse high", irq_clr, 1);
    @(negedge clk);
    check("R11 pulse low", irq_clr, 0);

    // R2 color table sweep
    for (int i = 0; i < 256; i++)
      wr(21'h080800 + 21'(8*i), 2'd2, {8'hAB, pal_val(i)});
    for (int i = 0; i < 256; i++) begin
      pix(8'(i), c); check("R2 pix lookup", c, pal_val(i));
      rd(21'h080800 + 21'(8*i), 2'd2, d); check("R2 bus read", d, {8'h00, pal_val(i)});
    end
    // R10 narrow writes into a color entry
    wr(21'h080800 + 21'(8*3) + 21'd1, 2'd0, 32'h0000_00C3);
    rd(21'h080800 + 21'(8*3), 2'd2, d);
    check("R10 palette byte merge", d, {8'h00, pal_val(3) & 24'hFF00FF | 24'h00C300});
    wr(21'h080800 + 21'(8*3) + 21'd2, 2'd1, 32'h0000_1234);
    rd(21'h080800 + 21'(8*3), 2'd2, d);
    check("R10 palette upper half", d, {8'h00, 8'h34, 8'hC3, pal_val(3)[7:0]});
    rd(21'h080800 + 21'(8*3) + 21'd2, 2'd0, d);
    check("R10 palette byte read", d, 32'h34);

    // R3 cursor bitmap sweep with byte writes (zero-fill on first write)
    for (int i = 0; i < 512; i++) begin
      wr(21'h081000 + 21'(8*i) + 21'd1, 2'd0, 32'(8'(i*7)));
      if (i == 20) begin
        rd(21'h081000 + 21'(8*20), 2'd2, d);
        check("R3 zero fill", d, {16'h0, 8'(20*7), 8'h00});
      end
      wr(21'h081000 + 21'(8*i), 2'd0, 32'(8'(i)));
      if (i % 64 == 5) wr(21'h081000 + 21'(8*i) + 21'd2, 2'd1, 32'hFFFF);
    end
    for (int i = 0; i < 512; i++) begin
      rd(21'h081000 + 21'(8*i), 2'd2, d);
      check("R3 bus read", d, {16'h0, 8'(i*7), 8'(i)});
      curs(9'(i), w); check("R3 curs lookup", w, {8'(i*7), 8'(i)});
    end
    rd(21'h081000 + 21'(8*9) + 21'd1, 2'd0, d); check("R10 pattern byte read", d, 32'(8'(63)));

    // R4 cursor colors
    for (int k = 0; k < 3; k++)
      wr(21'h080508 + 21'(8*k), 2'd2, 32'hFF00_0000 | (32'h10_2030 * (k + 1)));
    for (int k = 0; k < 3; k++) begin
      check("R4 curs_rgb", curs_rgb[24*k +: 24], 24'(32'h10_2030 * (k + 1)));
      rd(21'h080508 + 21'(8*k), 2'd2, d); check("R4 read", d, 32'h10_2030 * (k + 1));
    end
    rd(21'h080510 + 21'd1, 2'd0, d); check("R4 green byte", d, 32'h40);

    // R5 geometry scaling
    for (int v = 1; v < 1200; v += 97) begin
      wr(21'h080118, 2'd2, 32'(v)); check("R5 width", disp_width, 32'(v * 4));
      rd(21'h080118, 2'd2, d); check("R5 width read", d, 32'(v));
      wr(21'h080150, 2'd2, 32'(v)); check("R5 height", disp_height, 32'(v / 2));
      rd(21'h080150, 2'd2, d); check("R5 height read", d, 32'((v / 2) * 2));
    end
    wr(21'h080118, 2'd2, 32'hC000_0140); check("R5 width wrap", disp_width, 32'h500);
    wr(21'h080118, 2'd0, 32'h77); check("R10 width byte merge", disp_width, 32'h177 * 4);

    // R6 control word decode
    for (int s = 0; s < 8; s++) begin
      wr(21'h080300, 2'd2, (32'(s) << 20) | ((s % 2) ? 32'h400 : 0) | ((s > 3) ? 32'h80_0000 : 0));
      check("R6 depth", pix_depth, exp_depth(s));
      check("R6 blank", force_blank, (s % 2) ? 1 : 0);
      check("R6 cursor_off", cursor_off, (s > 3) ? 1 : 0);
      rd(21'h080300, 2'd2, d);
      check("R6 readback", d, (32'(s) << 20) | ((s % 2) ? 32'h400 : 0) | ((s > 3) ? 32'h80_0000 : 0));
    end

    // R10 lanes on the control word
    wr(21'h080300, 2'd2, 32'h1234_5678);
    for (int l = 0; l < 4; l++) begin
      rd(21'h080300 + 21'(l), 2'd0, d);
      check("R10 byte read", d, (32'h1234_5678 >> (8*l)) & 32'hFF);
    end
    rd(21'h080302, 2'd1, d); check("R10 half read hi", d, 32'h1234);
    rd(21'h080300, 2'd1, d); check("R10 half read lo", d, 32'h5678);
    wr(21'h080302, 2'd0, 32'hEE); check("R10 byte write", ctrl_word, 32'h12EE_5678);
    wr(21'h080302, 2'd1, 32'hBEEF); check("R10 half write", ctrl_word, 32'hBEEF_5678);

    // R7 start offset and cursor position
    wr(21'h080400, 2'd2, 32'h0003_2000); check("R7 top", top_offset, 32'h0003_2000);
    wr(21'h080638, 2'd2, 32'h0804_0123); check("R7 pos", curs_pos, 32'h0804_0123);
    rd(21'h080638, 2'd2, d); check("R7 pos read", d, 32'h0804_0123);
    wr(21'h080401, 2'd0, 32'h5A); check("R7 top byte", top_offset, 32'h0003_5A00);

    // R8 ignored writes
    s_ctrl = ctrl_word; s_w = disp_width; s_h = disp_height;
    s_top = top_offset; s_pos = curs_pos; s_crgb = curs_rgb;
    wr(21'h080000, 2'd2, 32'hFFFF_FFFF);
    for (int a = 21'h080108; a <= 21'h080170; a += 8)
      if (a != 21'h080118 && a != 21'h080150) wr(21'(a), 2'd2, 32'hFFFF_FFFF);
    wr(21'h080200, 2'd2, 32'hFFFF_FFFF);
    wr(21'h000100, 2'd2, 32'hFFFF_FFFF);
    check("R8 ctrl", ctrl_word, s_ctrl);
    check("R8 width", disp_width, s_w);
    check("R8 height", disp_height, s_h);
    check("R8 top", top_offset, s_top);
    check("R8 pos", curs_pos, s_pos);
    check("R8 cursor colors", curs_rgb, s_crgb);
    pix(8'd0, c); check("R8 palette intact", c, pal_val(0));
    rd(21'h000100, 2'd2, d); check("R8 unmapped read", d, 0);
    rd(21'h080108, 2'd2, d); check("R8 timing read", d, 0);

    // R9 clear register
    wr(21'h180000, 2'd2, 32'h0);
    check("R9 ctrl", ctrl_word, 0);
    check("R9 width", disp_width, 0);
    check("R9 height", disp_height, 0);
    check("R9 top", top_offset, 0);
    check("R9 pos", curs_pos, 0);
    check("R9 cursor colors", curs_rgb, 0);
    pix(8'd77, c); check("R9 pix lookup", c, 0);
    rd(21'h080800 + 21'(8*77), 2'd2, d); check("R9 palette read", d, 0);
    curs(9'd400, w); check("R9 curs lookup", w, 0);
    rd(21'h081000 + 21'(8*400), 2'd2, d); check("R9 pattern read", d, 0);
    wr(21'h081000 + 21'(8*400), 2'd0, 32'h99);
    rd(21'h081000 + 21'(8*400), 2'd2, d); check("R9 zero fill after clear", d, 32'h99);
    wr(21'h080800 + 21'(8*77) + 21'd2, 2'd0, 32'h42);
    pix(8'd77, c); check("R9 palette zero fill", c, 24'h420000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule